// File: doc/BRIEF.md
# SAR ADC Conversion Sequencer

This block is the digital control of an 8-bit successive-approximation converter. A five-bit cycle counter runs a fixed frame of eleven clock cycles. In cycle 1 the block takes a sample. In cycles 2 to 9 it resolves one bit per cycle, starting with the most significant bit. In cycle 10 it hands the finished code to an output holding register. In cycle 11 it clears the approximation register. The frames repeat back to back without gaps.

The block drives the sample-and-hold control and the 8-bit trial code for an external ladder DAC. That DAC feeds a comparator, and the comparator returns one bit, `cmp_above`, which is high when the held input is at or above the trial level. The holding register drives a second DAC that rebuilds the signal. The holding register keeps the previous result steady while the next conversion runs. A one-cycle `done` pulse marks the cycle in which the result is transferred.

Top module: `sar_conv_seq`

## Requirements
- R1: The reset is synchronous and active low. While `rst_n` is low at a clock edge, the block clears its counter, its approximation register and its holding register. `trial_code` and `result` then read 0, and `sample_hold` and `done` stay low.
- R2: A frame lasts exactly 11 cycles. Cycle 1 is the first cycle after the first rising edge with `rst_n` high. `sample_hold` is high in cycle 1 of each frame and low in all other cycles.
- R3: In trial cycle k (k = 2 to 9), bit 9-k of `trial_code` is 1 and all bits below it are 0. Bit 7 is tested first and bit 0 last.
- R4: At the end of a trial cycle, the bit under test is cleared if `cmp_above` is low and kept if `cmp_above` is high. Bits above it do not change.
- R5: In cycle 10, `trial_code` holds the final code, and `done` is high in that cycle only. With an ideal comparator (`cmp_above` = input ≥ `trial_code`), the final code equals the integer input value (0 to 255).
- R6: `result` loads `trial_code` at the end of cycle 10. At all other edges outside reset, `result` keeps its value.
- R7: The approximation register is cleared at the end of cycle 11, so `trial_code` reads 0 in cycle 1 of every frame. `trial_code` still shows the final code during cycle 11.
- R8: At most one internal control strobe is active in any cycle, so `sample_hold` and `done` are never high together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cmp_above | input | 1 | Comparator: 1 when the held input is at or above the trial level |
| sample_hold | output | 1 | Sample-and-hold control, high in cycle 1 of a frame |
| trial_code | output | 8 | Trial code driving the conversion ladder DAC |
| result | output | 8 | Holding register output to the reconstruction DAC |
| done | output | 1 | One-cycle pulse in the transfer cycle |

## Verification
The hardest situation to reach from the ports is a reset that arrives part way through a frame, while the holding register still carries a non-zero earlier result. The stimulus first sweeps all 256 input values through back-to-back frames. The last value of the sweep is 255, so the holding register is left full. The bench then drops the reset in the middle of the next conversion. It checks that every output returns to zero, and that the first frame after release starts cleanly with a sample cycle. Each trial cycle of the sweep is compared against an expected trial code computed from the swept value and the bit position.

// File: rtl/sar_seq_pkg.sv
// Package: shared sizes and the control strobe type for the SAR sequencer.
// Assumes one resolution parameter; every frame position is derived from it.
package sar_seq_pkg;
    localparam int RES_W     = 8;            // converted code width
    localparam int CNT_W     = 5;            // frame counter width
    localparam int IDX_W     = $clog2(RES_W);
    localparam int FRAME_LEN = RES_W + 3;    // sample, trials, transfer, clear

    typedef struct packed {
        logic sample;   // sample-and-hold window
        logic step;     // one bit trial
        logic xfer;     // copy code to holding register
        logic clr;      // clear approximation register
    } sar_strobe_t;
endpackage

// File: rtl/sar_frame_counter.sv
// Module: frame counter and strobe decoder.
// Counts 0 after reset, then 1..FRAME_LEN repeating. Decodes one strobe per
// cycle and the index of the bit under trial. Assumes FRAME_LEN < 2**CW.
module sar_frame_counter
    import sar_seq_pkg::*;
#(
    parameter int W  = RES_W,
    parameter int CW = CNT_W,
    parameter int IW = IDX_W
) (
    input  logic          clk,
    input  logic          rst_n,
    output sar_strobe_t   strb,
    output logic [IW-1:0] bit_idx
);
    localparam int LAST      = W + 3;
    localparam int LAST_STEP = W + 1;
    localparam int XFER_AT   = W + 2;

    logic [CW-1:0] cnt;
    logic [CW-1:0] rem;

    // Advance the frame position, wrapping from the last cycle to cycle 1.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (cnt == CW'(LAST))
            cnt <= CW'(1);
        else
            cnt <= cnt + 1'b1;
    end

    // Decode the strobes and the bit under trial from the frame position.
    always_comb begin
        strb.sample = (cnt == CW'(1));
        strb.step   = (cnt >= CW'(2)) && (cnt <= CW'(LAST_STEP));
        strb.xfer   = (cnt == CW'(XFER_AT));
        strb.clr    = (cnt == CW'(LAST));
        rem         = CW'(LAST_STEP) - cnt;
        bit_idx     = rem[IW-1:0];
    end

    AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CW'(LAST));                                           // R2
    AST_CNT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == CW'(LAST)) |=> (cnt == CW'(1)));                     // R7
    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt != CW'(LAST)) |=> (cnt == $past(cnt) + 1'b1));          // R2
    AST_STROBE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({strb.sample, strb.step, strb.xfer, strb.clr}));    // R8
endmodule

// File: rtl/sar_bit_engine.sv
// Module: successive-approximation register.
// Seeds the MSB on the sample strobe. On each step strobe it keeps or drops
// the bit under trial from the comparator and sets the next lower bit.
// Clears on the clear strobe. Assumes bit_idx is in range while step is high.
module sar_bit_engine
    import sar_seq_pkg::*;
#(
    parameter int W  = RES_W,
    parameter int IW = IDX_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sample,
    input  logic          step,
    input  logic          clr,
    input  logic [IW-1:0] bit_idx,
    input  logic          cmp_above,
    output logic [W-1:0]  code
);
    localparam logic [W-1:0] MSB_ONLY = {1'b1, {(W-1){1'b0}}};

    logic [W-1:0] code_nxt;

    // Work out the next trial code from the strobe in force.
    always_comb begin
        code_nxt = code;
        if (sample) begin
            code_nxt = MSB_ONLY;
        end else if (step) begin
            code_nxt[bit_idx] = cmp_above;
            if (bit_idx != '0)
                code_nxt[bit_idx - 1'b1] = 1'b1;
        end else if (clr) begin
            code_nxt = '0;
        end
    end

    // Register the trial code.
    always_ff @(posedge clk) begin
        if (!rst_n)
            code <= '0;
        else
            code <= code_nxt;
    end

    AST_SEED_MSB: assert property (@(posedge clk) disable iff (!rst_n)
        sample |=> (code == MSB_ONLY));                              // R3
    AST_DECIDE: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> (code[$past(bit_idx)] == $past(cmp_above)));        // R4
    AST_NEXT_TRIAL: assert property (@(posedge clk) disable iff (!rst_n)
        (step && bit_idx != '0) |=> code[$past(bit_idx) - 1'b1]);    // R3
    AST_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (code == '0));                                       // R7
endmodule

// File: rtl/sar_hold_reg.sv
// Module: output holding register for the reconstruction DAC.
// Loads only on its load strobe and holds its value at every other edge.
module sar_hold_reg
    import sar_seq_pkg::*;
#(
    parameter int W = RES_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    // Capture the finished code on the transfer strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)
            q <= '0;
        else if (load)
            q <= d;
    end

    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(q));                                       // R6
    AST_HOLD_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (q == $past(d)));                                   // R6
endmodule

// File: rtl/sar_conv_seq.sv
// Module: top of the SAR conversion sequencer.
// Joins the frame counter, the approximation register and the holding
// register. Assumes an external DAC and comparator close the loop through
// trial_code and cmp_above within one cycle.
module sar_conv_seq
    import sar_seq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmp_above,
    output logic             sample_hold,
    output logic [RES_W-1:0] trial_code,
    output logic [RES_W-1:0] result,
    output logic             done
);
    sar_strobe_t      strb;
    logic [IDX_W-1:0] bit_idx;

    sar_frame_counter #(.W(RES_W), .CW(CNT_W), .IW(IDX_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .strb    (strb),
        .bit_idx (bit_idx)
    );

    sar_bit_engine #(.W(RES_W), .IW(IDX_W)) u_sar (
        .clk       (clk),
        .rst_n     (rst_n),
        .sample    (strb.sample),
        .step      (strb.step),
        .clr       (strb.clr),
        .bit_idx   (bit_idx),
        .cmp_above (cmp_above),
        .code      (trial_code)
    );

    sar_hold_reg #(.W(RES_W)) u_hold (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (strb.xfer),
        .d     (trial_code),
        .q     (result)
    );

    // Bring the sample and transfer strobes out to the ports.
    always_comb begin
        sample_hold = strb.sample;
        done        = strb.xfer;
    end

    AST_DONE_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (result == $past(trial_code)));                     // R5
    AST_SH_NOT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        !(sample_hold && done));                                     // R8
    AST_SAMPLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        sample_hold |-> (trial_code == '0));                         // R7
endmodule

// File: tb/tb_sar_conv_seq.sv
`timescale 1ns/1ps
module tb_sar_conv_seq;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmp_above;
    logic       sample_hold;
    logic [7:0] trial_code;
    logic [7:0] result;
    logic       done;
    int         held = 0;
    int         checks = 0;
    int         errors = 0;
    bit         finished = 1'b0;

    always #2 clk = ~clk;

    // Ideal comparator against the held input.
    assign cmp_above = (held >= int'(trial_code));

    sar_conv_seq dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmp_above   (cmp_above),
        .sample_hold (sample_hold),
        .trial_code  (trial_code),
        .result      (result),
        .done        (done)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // One full frame: the input is sampled in cycle 1, prev is the result from the frame before.
    task automatic run_frame(input int v, inout int prev);
        for (int k = 1; k <= 11; k++) begin
            @(negedge clk);
            if (k == 1) begin
                held = v;
                chk(sample_hold == 1'b1, "R2", "sample_hold cycle 1", int'(sample_hold), 1);
                chk(trial_code == 8'd0, "R7", "trial_code cycle 1", int'(trial_code), 0);
                chk(result == 8'(prev), "R6", "result kept cycle 1", int'(result), prev);
                chk(done == 1'b0, "R8", "done cycle 1", int'(done), 0);
            end else if (k <= 9) begin
                int idx = 9 - k;
                int expc = (v & ~((1 << (idx + 1)) - 1)) | (1 << idx);
                chk(trial_code == 8'(expc), "R3 R4", "trial code", int'(trial_code), expc);
                chk(!sample_hold && !done, "R2", "strobes low in trial",
                    int'({sample_hold, done}), 0);
            end else if (k == 10) begin
                chk(trial_code == 8'(v), "R5", "final code", int'(trial_code), v);
                chk(done == 1'b1, "R5", "done cycle 10", int'(done), 1);
                chk(result == 8'(prev), "R6", "result kept cycle 10", int'(result), prev);
            end else begin
                chk(result == 8'(v), "R6", "result loaded", int'(result), v);
                chk(!sample_hold && !done, "R8", "strobes low cycle 11",
                    int'({sample_hold, done}), 0);
                chk(trial_code == 8'(v), "R7", "code kept cycle 11", int'(trial_code), v);
            end
        end
        prev = v;
    endtask

    task automatic check_reset_state(input string tag);
        chk(trial_code == 8'd0, "R1", {tag, " trial_code"}, int'(trial_code), 0);
        chk(result == 8'd0, "R1", {tag, " result"}, int'(result), 0);
        chk(!sample_hold && !done, "R1", {tag, " strobes"}, int'({sample_hold, done}), 0);
    endtask

    initial begin
        int prev = 0;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check_reset_state("power-up");
        rst_n = 1'b1;
        // Sweep every input value through back-to-back frames.
        for (int v = 0; v < 256; v++) run_frame(v, prev);
        // Reset in the middle of a conversion while result holds 255.
        repeat (4) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check_reset_state("mid-frame");
        @(negedge clk);
        check_reset_state("held");
        rst_n = 1'b1;
        prev = 0;
        run_frame(8'hA5, prev);
        run_frame(8'h5A, prev);
        run_frame(8'h80, prev);
        run_frame(8'h7F, prev);
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #(4 * 20000);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule